// File: doc/BRIEF.md
# Modem Handshake Status and Loopback Unit

This unit watches the four active-low handshake inputs of a serial port: clear-to-send, data-set-ready, ring indicator and carrier detect. It also drives the two active-low handshake outputs, data-terminal-ready and request-to-send, from a small control register. Each input is resynchronised to the core clock. The unit keeps the asserted state of every line and a sticky change flag for each line. It raises an interrupt request while a flag is set and the interrupt is enabled.

Software writes the control register and reads an 8-bit status byte. The read strobe clears the change flags. A loopback bit in the control register is for diagnostics. While it is set, the external inputs are disconnected and the line states come from control bits. Software can then create change events and interrupts with no activity on the pins. During loopback the two outputs are held inactive, and a loopback-active output tells neighbouring logic, such as the serial datapath, to reroute its own data.

Top module: `modem_status_loop`

## Requirements
- R1: After reset the status byte reads 0x00, the control readback is 0x00, `dtr_n` and `rts_n` are 1, and `irq` and `loop_active` are 0.
- R2: In normal mode, status bits 4, 5, 6 and 7 show the asserted (inverted) level of `cts_n`, `dsr_n`, `ri_n` and `dcd_n`. A pin change appears on the status byte exactly SYNC_STAGES+1 rising clock edges after it is applied.
- R3: Status bits 0 (clear-to-send), 1 (data-set-ready) and 3 (carrier) set when the state bit of that line changes in either direction.
- R4: Status bit 2 sets only when the ring state rises from 0 to 1. A falling ring state leaves it unchanged.
- R5: A cycle with `sts_rd` high clears all change flags at the next edge. A change that lands on that same edge leaves its own flag set.
- R6: One transition sets its flag once. After a clear, the flag stays 0 while the line is steady.
- R7: Control bits are: 0 data-terminal-ready, 1 request-to-send, 2 and 3 auxiliary, 4 loopback. `ctl_rdata` returns them in bits 4:0, with bits 7:5 at 0. In normal mode `dtr_n` = NOT bit 0 and `rts_n` = NOT bit 1.
- R8: In loopback, the clear-to-send state follows control bit 1, data-set-ready follows bit 0, ring follows bit 2 and carrier follows bit 3. The four input pins have no effect.
- R9: In loopback, `dtr_n` and `rts_n` are 1 and `loop_active` is 1.
- R10: In loopback, `ctl_rdata` bits 1:0 read as 0.
- R11: `irq` is 1 exactly when `irq_en` is 1 and at least one change flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data (bit map in R7) |
| ctl_rdata | output | 8 | Control register readback |
| sts_rd | input | 1 | Status read strobe, clears change flags |
| sts_rdata | output | 8 | Status byte: line states 7:4, change flags 3:0 |
| irq_en | input | 1 | Modem status interrupt enable |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| irq | output | 1 | Modem status interrupt request |
| loop_active | output | 1 | Loopback mode indicator |

## Verification
The bench builds the unit with SYNC_STAGES set to 3 instead of the default 2. The input-to-status latency is then four edges. A hard-wired two-stage chain, or a missing state register, shows up as a one-edge shift, and the edge-exact latency check catches it. With this setting, pin changes and loopback control writes can be lined up with read strobes. That lets the bench land a change on the very edge that clears the flags.

// File: rtl/msl_pkg.sv
package msl_pkg;
  localparam int NUM_LINES = 4;
  localparam int LN_CTS    = 0;
  localparam int LN_DSR    = 1;
  localparam int LN_RI     = 2;
  localparam int LN_DCD    = 3;
  localparam int CTL_W     = 5;

  typedef struct packed {
    logic loop_en;
    logic aux_b;
    logic aux_a;
    logic rts_on;
    logic dtr_on;
  } ctl_t;

  // ring indicator flags only its rising state edge
  localparam logic [NUM_LINES-1:0] RISE_ONLY_MASK = 4'b0100;
endpackage

// File: rtl/msl_sync.sv
module msl_sync #(
  parameter int WIDTH   = 4,
  parameter int STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] chain_d;
      if (s == 0) begin : g_first
        assign chain_d = async_in;
      end else begin : g_next
        assign chain_d = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RST_VAL;
        else        chain_q[s] <= chain_d;
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/msl_ctrl_reg.sv
module msl_ctrl_reg
  import msl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             ctl_q
);
  ctl_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = ctl_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end
endmodule

// File: rtl/msl_delta.sv
module msl_delta #(
  parameter int N = 4,
  parameter logic [N-1:0] RISE_ONLY = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_next,
  input  logic         clr,
  output logic [N-1:0] state_q,
  output logic [N-1:0] delta_q
);
  logic [N-1:0] change;
  logic [N-1:0] delta_d;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_line
      if (RISE_ONLY[i]) begin : g_rise
        assign change[i] = line_next[i] & ~state_q[i];
        AST_RISE_ONLY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
          $rose(delta_q[i]) |-> $rose(state_q[i])); // R4
      end else begin : g_any
        assign change[i] = line_next[i] ^ state_q[i];
        AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
          $rose(delta_q[i]) |-> (state_q[i] != $past(state_q[i]))); // R3
      end
      // a change on the clearing edge wins over the clear
      assign delta_d[i] = change[i] | (delta_q[i] & ~clr);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      delta_q <= '0;
    end else begin
      state_q <= line_next;
      delta_q <= delta_d;
    end
  end

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr) && $stable(state_q)) |-> (delta_q == '0)); // R5
endmodule

// File: rtl/modem_status_loop.sv
module modem_status_loop
  import msl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REG_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [REG_W-1:0] ctl_rdata,
  input  logic             sts_rd,
  output logic [REG_W-1:0] sts_rdata,
  input  logic             irq_en,
  input  logic             cts_n,
  input  logic             dsr_n,
  input  logic             ri_n,
  input  logic             dcd_n,
  output logic             dtr_n,
  output logic             rts_n,
  output logic             irq,
  output logic             loop_active
);
  localparam int PAD_W = REG_W - CTL_W;

  ctl_t                 ctl_q;
  logic [NUM_LINES-1:0] pins_raw_n;
  logic [NUM_LINES-1:0] pins_sync_n;
  logic [NUM_LINES-1:0] pin_level;
  logic [NUM_LINES-1:0] loop_level;
  logic [NUM_LINES-1:0] line_next;
  logic [NUM_LINES-1:0] line_state;
  logic [NUM_LINES-1:0] line_delta;

  assign pins_raw_n[LN_CTS] = cts_n;
  assign pins_raw_n[LN_DSR] = dsr_n;
  assign pins_raw_n[LN_RI]  = ri_n;
  assign pins_raw_n[LN_DCD] = dcd_n;

  msl_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pins_raw_n),
    .sync_out (pins_sync_n)
  );

  msl_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ctl_wr),
    .wdata (ctl_wdata),
    .ctl_q (ctl_q)
  );

  assign pin_level = ~pins_sync_n;

  assign loop_level[LN_CTS] = ctl_q.rts_on;
  assign loop_level[LN_DSR] = ctl_q.dtr_on;
  assign loop_level[LN_RI]  = ctl_q.aux_a;
  assign loop_level[LN_DCD] = ctl_q.aux_b;

  assign line_next = ctl_q.loop_en ? loop_level : pin_level;

  msl_delta #(.N(NUM_LINES), .RISE_ONLY(RISE_ONLY_MASK)) u_delta (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_next (line_next),
    .clr       (sts_rd),
    .state_q   (line_state),
    .delta_q   (line_delta)
  );

  assign sts_rdata   = {line_state, line_delta};
  assign irq         = irq_en & (|line_delta);
  assign loop_active = ctl_q.loop_en;
  assign dtr_n       = ~(ctl_q.dtr_on & ~ctl_q.loop_en);
  assign rts_n       = ~(ctl_q.rts_on & ~ctl_q.loop_en);
  assign ctl_rdata   = {{PAD_W{1'b0}}, ctl_q.loop_en, ctl_q.aux_b, ctl_q.aux_a,
                        ctl_q.rts_on & ~ctl_q.loop_en, ctl_q.dtr_on & ~ctl_q.loop_en};

  AST_LOOP_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    loop_active |-> (dtr_n && rts_n)); // R9
  AST_LOOP_RB_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    loop_active |-> (ctl_rdata[1:0] == 2'b00)); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq); // R11
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_rdata[3:0] != 4'h0)); // R11
endmodule

// File: tb/test_modem_status_loop.sv
`timescale 1ns/1ps
module test_modem_status_loop;
  localparam int SYNC = 3;
  localparam int LAT  = SYNC + 1;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr;
  logic [4:0] ctl_wdata;
  logic [7:0] ctl_rdata;
  logic       sts_rd;
  logic [7:0] sts_rdata;
  logic       irq_en;
  logic       cts_n, dsr_n, ri_n, dcd_n;
  logic       dtr_n, rts_n, irq, loop_active;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  modem_status_loop #(.SYNC_STAGES(SYNC)) i_modem_status_loop (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .sts_rd(sts_rd), .sts_rdata(sts_rdata),
    .irq_en(irq_en), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .irq(irq), .loop_active(loop_active)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [4:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    tick(1);
    ctl_wr = 1'b0;
  endtask

  task automatic rd_sts(output logic [7:0] v);
    sts_rd = 1'b1;
    #1 v = sts_rdata;
    tick(1);
    sts_rd = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 status", sts_rdata, 8'h00);
    chk("R1 ctl", ctl_rdata, 8'h00);
    chk("R1 pins/irq", {4'h0, dtr_n, rts_n, irq, loop_active}, 8'h0C);
  endtask

  task automatic t_latency;
    logic [7:0] v;
    cts_n = 1'b0;
    tick(LAT - 1);
    chk("R2 before latency", sts_rdata, 8'h00);
    tick(1);
    chk("R2 R3 cts state and flag", sts_rdata, 8'h11);
    rd_sts(v);
    chk("R5 read value", v, 8'h11);
    chk("R5 flags cleared", sts_rdata, 8'h10);
    tick(5);
    chk("R6 no repeat flag", sts_rdata, 8'h10);
  endtask

  task automatic t_both_dir;
    logic [7:0] v;
    cts_n = 1'b1;
    tick(LAT);
    chk("R3 cts falling state", sts_rdata, 8'h01);
    dsr_n = 1'b0; dcd_n = 1'b0;
    tick(LAT);
    chk("R3 dsr dcd set", sts_rdata, 8'hAB);
    rd_sts(v);
    chk("R5 cleared", sts_rdata, 8'hA0);
  endtask

  task automatic t_ring;
    logic [7:0] v;
    ri_n = 1'b0;
    tick(LAT);
    chk("R4 ring rise flagged", sts_rdata, 8'hE4);
    rd_sts(v);
    ri_n = 1'b1;
    tick(LAT + 2);
    chk("R4 ring fall not flagged", sts_rdata, 8'hA0);
    dsr_n = 1'b1; dcd_n = 1'b1;
    tick(LAT);
    rd_sts(v);
    chk("R2 idle again", sts_rdata, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    irq_en = 1'b0;
    cts_n = 1'b0;
    tick(LAT);
    chk("R11 irq masked", {7'h0, irq}, 8'h00);
    irq_en = 1'b1;
    #1 chk("R11 irq raised", {7'h0, irq}, 8'h01);
    rd_sts(v);
    chk("R11 irq drops on clear", {7'h0, irq}, 8'h00);
    irq_en = 1'b0;
    cts_n = 1'b1;
    tick(LAT);
    rd_sts(v);
    chk("R3 cts back idle", sts_rdata, 8'h00);
  endtask

  task automatic t_ctrl;
    wr_ctl(5'h03);
    chk("R7 readback", ctl_rdata, 8'h03);
    chk("R7 outputs on", {6'h0, dtr_n, rts_n}, 8'h00);
    wr_ctl(5'h0D);
    chk("R7 readback aux", ctl_rdata, 8'h0D);
    chk("R7 dtr only", {6'h0, dtr_n, rts_n}, 8'h01);
    tick(2);
    chk("R7 normal mode status unaffected", sts_rdata, 8'h00);
  endtask

  task automatic t_loop;
    logic [7:0] v;
    wr_ctl(5'h10);
    chk("R9 loop outputs", {5'h0, dtr_n, rts_n, loop_active}, 8'h07);
    chk("R10 readback", ctl_rdata, 8'h10);
    tick(2);
    chk("R8 loop idle status", sts_rdata, 8'h00);
    wr_ctl(5'h13);
    chk("R10 low bits masked", ctl_rdata, 8'h10);
    chk("R9 outputs held idle", {6'h0, dtr_n, rts_n}, 8'h03);
    tick(1);
    chk("R8 cts from bit1 dsr from bit0", sts_rdata, 8'h33);
    rd_sts(v);
    cts_n = 1'b0; dsr_n = 1'b0; ri_n = 1'b0; dcd_n = 1'b0;
    tick(LAT + 2);
    chk("R8 pins ignored", sts_rdata, 8'h30);
    wr_ctl(5'h1C);
    tick(1);
    chk("R8 R4 ring and dcd from bits 2 3", sts_rdata, 8'hCF);
    wr_ctl(5'h14);
    rd_sts(v);
    chk("R5 read value before conflict", v, 8'hCF);
    chk("R5 change on read edge kept", sts_rdata, 8'h48);
    wr_ctl(5'h00);
    chk("R9 loop off", {7'h0, loop_active}, 8'h00);
    tick(2);
    rd_sts(v);
    chk("R2 pins seen after loop", sts_rdata, 8'hF0);
    cts_n = 1'b1; dsr_n = 1'b1; ri_n = 1'b1; dcd_n = 1'b1;
    tick(LAT);
    rd_sts(v);
    chk("R2 final idle", sts_rdata, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; sts_rd = 1'b0; irq_en = 1'b0;
    cts_n = 1'b1; dsr_n = 1'b1; ri_n = 1'b1; dcd_n = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_latency();
    t_both_dir();
    t_ring();
    t_irq();
    t_ctrl();
    t_loop();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule